// File: doc/BRIEF.md
# Buffered Burst Byte-Count Controller

This block moves a counted burst of bytes between a serial-bus protocol engine and a local byte buffer of 68 entries. The host sets up a count register: seven bits of byte count and a top bit that chooses how a receive burst ends. It then fills or drains the buffer through a single data port and launches the burst with a control write. From that point the controller serves the engine one byte at a time, with no help from the host. It stops when the count is used up, when a transmitted byte is not acknowledged, or when the bus signals STOP.

When a burst ends, the controller raises an interrupt and loads a status code. It returns the buffer pointer to entry zero and overwrites the count field with the number of bytes actually moved. The host can then read the received bytes from the start of the buffer. A count of zero, or one larger than the buffer, is refused at once with its own status code, and nothing reaches the engine. The engine is abstracted as a byte handshake. While `eng_req` is high, the controller offers a byte or asks for one. The engine closes each byte with a one-cycle `eng_done`, or ends the burst with `eng_stop`.

The sequencer has four states. IDLE accepts host traffic. Start with a valid count goes to XFER, and start with an invalid count goes to REJECT. XFER serves the engine and goes to WRAP on the last byte, on a NACK or on STOP. WRAP raises the interrupt and reports the outcome, then returns to IDLE. REJECT raises the interrupt with the bad-count code, then returns to IDLE.

Top module: `i2c_burst_ctrl`

## Requirements
- R1: After reset, `irq` is 0, `status` is F8h, `cnt_rdata` is 00h and `eng_req` is 0.
- R2: In IDLE, each host data write stores `dat_wdata` at the pointer and advances it, and each data read strobe advances it. `dat_rdata` always shows the entry at the pointer. An access at or past min(count, 68) is ignored, and a count write returns the pointer to entry 0.
- R3: A start with count field 00h or above 44h moves no byte. Two cycles later `irq` is 1 and `status` is FCh, and `cnt_rdata` keeps the written value.
- R4: A transmit burst (`ctl_rx`=0) offers buffer entries 0..count-1 on `eng_txbyte` in order. When every byte is acknowledged (`eng_ack`=1), it ends with status 28h.
- R5: A transmit byte answered with `eng_ack`=0 ends the burst at once with status 30h. That byte counts as moved.
- R6: In a receive burst (`ctl_rx`=1) with count bit 7 clear, `eng_nack` is 0 for every byte. Each `eng_rxbyte` is stored in order, and a full burst ends with status 50h.
- R7: In a receive burst with count bit 7 set, `eng_nack` is 1 only for the final counted byte, and the full burst ends with status 58h.
- R8: `eng_stop` during a burst ends it with status A0h. The byte in flight is not counted.
- R9: At the end of a burst, `irq` rises, `cnt_rdata` reads {bit 7 as written, bytes moved}, and the pointer is back at entry 0.
- R10: A control write with `ctl_buffered`=0 is ignored: no transfer, no interrupt, status unchanged.
- R11: A start while `irq` is 1 is ignored. `irq_clr` drops `irq` and returns `status` to F8h.
- R12: In a transmit burst, `eng_nack` stays 0 whatever count bit 7 holds, and the full count, including 44h, is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wr | input | 1 | Write strobe for the count register |
| cnt_wdata | input | 8 | {receive last-byte NACK select, byte count[6:0]} |
| cnt_rdata | output | 8 | Count register readback |
| dat_wr | input | 1 | Host buffer write strobe |
| dat_wdata | input | 8 | Host buffer write data |
| dat_rd | input | 1 | Host buffer read strobe (advances pointer) |
| dat_rdata | output | 8 | Buffer entry at the pointer |
| ctl_wr | input | 1 | Control write strobe |
| ctl_buffered | input | 1 | Buffered-operation select; must be 1 for the write to act |
| ctl_rx | input | 1 | Burst direction: 1 receive, 0 transmit |
| ctl_go | input | 1 | Start request |
| irq_clr | input | 1 | Clears the interrupt |
| irq | output | 1 | Interrupt flag |
| status | output | 8 | Outcome code |
| eng_req | output | 1 | Byte requested from or offered to the engine |
| eng_rx | output | 1 | Current burst is a receive |
| eng_txbyte | output | 8 | Byte offered to the engine |
| eng_nack | output | 1 | Engine must NACK this received byte |
| eng_done | input | 1 | Engine finished the current byte |
| eng_ack | input | 1 | Receiver acknowledged the transmitted byte |
| eng_rxbyte | input | 8 | Byte received by the engine |
| eng_stop | input | 1 | STOP seen on the bus |

## Verification
The bench builds the block with its defaults: a 68-entry buffer, 8-bit data and a 7-bit count field. This size makes a full 44h burst and the first illegal count, 45h, both directly reachable. The same run also reaches pointer clamping past the buffer and NACK or STOP at the first or last byte. Random bursts of random length, direction, last-byte setting and engine latency, with NACKs and STOPs placed at random, run alongside the directed corner cases.

// File: rtl/bxf_pkg.sv
package bxf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_WRAP,
        ST_REJECT
    } seq_state_e;

    typedef enum logic [1:0] {
        END_FULL,
        END_NACK,
        END_STOP
    } end_cause_e;

    localparam logic [7:0] STAT_IDLE    = 8'hF8;
    localparam logic [7:0] STAT_BADCNT  = 8'hFC;
    localparam logic [7:0] STAT_TX_ALL  = 8'h28;
    localparam logic [7:0] STAT_TX_NACK = 8'h30;
    localparam logic [7:0] STAT_RX_ACK  = 8'h50;
    localparam logic [7:0] STAT_RX_NACK = 8'h58;
    localparam logic [7:0] STAT_STOP    = 8'hA0;

endpackage

// File: rtl/bxf_buffer.sv
module bxf_buffer #(
    parameter int DEPTH = 68,
    parameter int DW    = 8,
    parameter int CW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [CW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam logic [CW-1:0] LAST_IDX = CW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic          in_range;

    assign in_range = (addr <= LAST_IDX);

    always_ff @(posedge clk) begin
        if (we && in_range) begin
            mem[addr] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (in_range) begin
            rdata = mem[addr];
        end
    end

    // R2: a write never targets an entry outside the storage
    assert_wr_in_range_R2: assert property (@(posedge clk) we |-> (addr <= LAST_IDX));

endmodule

// File: rtl/bxf_count.sv
module bxf_count #(
    parameter int DEPTH = 68,
    parameter int CW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW:0]   wdata,
    input  logic          moved_clr,
    input  logic          moved_inc,
    input  logic          moved_load,
    output logic [CW:0]   cnt_rdata,
    output logic          lb,
    output logic [CW-1:0] bound,
    output logic          cnt_ok,
    output logic          last_pos,
    output logic [CW-1:0] moved
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic          lb_q;
    logic [CW-1:0] bc_q;
    logic [CW-1:0] moved_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lb_q    <= 1'b0;
            bc_q    <= '0;
            moved_q <= '0;
        end else begin
            if (wr_en) begin
                lb_q <= wdata[CW];
                bc_q <= wdata[CW-1:0];
            end else if (moved_load) begin
                bc_q <= moved_q;
            end
            if (moved_clr) begin
                moved_q <= '0;
            end else if (moved_inc) begin
                moved_q <= moved_q + CW'(1);
            end
        end
    end

    always_comb begin
        cnt_rdata = {lb_q, bc_q};
        lb        = lb_q;
        moved     = moved_q;
        cnt_ok    = (bc_q != '0) && (bc_q <= DEPTH_C);
        bound     = (bc_q > DEPTH_C) ? DEPTH_C : bc_q;
        last_pos  = ((moved_q + CW'(1)) == bc_q);
    end

    // R4: the moved counter only advances while it is below the requested count
    assert_inc_below_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        moved_inc |-> (moved_q < bc_q));

endmodule

// File: rtl/bxf_seq.sv
module bxf_seq #(
    parameter int DEPTH = 68,
    parameter int CW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dat_wr,
    input  logic          dat_rd,
    input  logic          cnt_wr,
    input  logic          ctl_wr,
    input  logic          ctl_buffered,
    input  logic          ctl_rx,
    input  logic          ctl_go,
    input  logic          irq_clr,
    input  logic [CW-1:0] bound,
    input  logic          lb,
    input  logic          cnt_ok,
    input  logic          last_pos,
    input  logic          eng_done,
    input  logic          eng_ack,
    input  logic          eng_stop,
    output logic [CW-1:0] ptr,
    output logic          buf_we,
    output logic          buf_from_eng,
    output logic          cnt_load_ok,
    output logic          moved_clr,
    output logic          moved_inc,
    output logic          moved_load,
    output logic          eng_req,
    output logic          eng_rx,
    output logic          eng_nack,
    output logic          irq,
    output logic [7:0]    status
);
    import bxf_pkg::*;

    seq_state_e state_q, state_d;
    end_cause_e cause_q, cause_d;
    logic       rx_q;
    logic       in_idle, in_xfer;
    logic       host_room, host_step, eng_step, start_ok;
    logic [7:0] wrap_code;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= END_FULL;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    // Outputs and strobes decoded from the current state
    always_comb begin
        in_idle      = (state_q == ST_IDLE);
        in_xfer      = (state_q == ST_XFER);
        host_room    = (ptr < bound);
        host_step    = in_idle && (dat_wr || dat_rd) && host_room;
        eng_step     = in_xfer && eng_done && !eng_stop;
        start_ok     = in_idle && ctl_wr && ctl_buffered && ctl_go && !irq;
        buf_we       = (in_idle && dat_wr && host_room) || (eng_step && rx_q);
        buf_from_eng = in_xfer;
        cnt_load_ok  = in_idle;
        moved_clr    = start_ok;
        moved_inc    = eng_step;
        moved_load   = (state_q == ST_WRAP);
        eng_req      = in_xfer;
        eng_rx       = in_xfer && rx_q;
        eng_nack     = in_xfer && rx_q && lb && last_pos;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) begin
                    state_d = cnt_ok ? ST_XFER : ST_REJECT;
                end
            end
            ST_XFER: begin
                if (eng_stop) begin
                    state_d = ST_WRAP;
                    cause_d = END_STOP;
                end else if (eng_done) begin
                    if (!rx_q && !eng_ack) begin
                        state_d = ST_WRAP;
                        cause_d = END_NACK;
                    end else if (last_pos) begin
                        state_d = ST_WRAP;
                        cause_d = END_FULL;
                    end
                end
            end
            ST_WRAP:   state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (cause_q)
            END_STOP: wrap_code = STAT_STOP;
            END_NACK: wrap_code = STAT_TX_NACK;
            default:  wrap_code = rx_q ? (lb ? STAT_RX_NACK : STAT_RX_ACK) : STAT_TX_ALL;
        endcase
    end

    // Pointer, interrupt and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            rx_q   <= 1'b0;
            irq    <= 1'b0;
            status <= STAT_IDLE;
        end else begin
            if (start_ok) begin
                ptr  <= '0;
                rx_q <= ctl_rx;
            end else if (cnt_wr && in_idle) begin
                ptr <= '0;
            end else if (host_step || eng_step) begin
                ptr <= ptr + CW'(1);
            end

            if (state_q == ST_WRAP) begin
                ptr    <= '0;
                irq    <= 1'b1;
                status <= wrap_code;
            end else if (state_q == ST_REJECT) begin
                ptr    <= '0;
                irq    <= 1'b1;
                status <= STAT_BADCNT;
            end else if (irq_clr && irq) begin
                irq    <= 1'b0;
                status <= STAT_IDLE;
            end
        end
    end

    // R11: the interrupt stays up until the host clears it
    assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R9: a rising interrupt finds the pointer back at entry zero
    assert_ptr_home_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (ptr == '0));

    // R3: a refused count never leads to engine activity
    assert_badcnt_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STAT_BADCNT) |-> !eng_req);

endmodule

// File: rtl/i2c_burst_ctrl.sv
module i2c_burst_ctrl #(
    parameter int DEPTH = 68,
    parameter int DW    = 8,
    parameter int CW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_wr,
    input  logic [CW:0]   cnt_wdata,
    output logic [CW:0]   cnt_rdata,
    input  logic          dat_wr,
    input  logic [DW-1:0] dat_wdata,
    input  logic          dat_rd,
    output logic [DW-1:0] dat_rdata,
    input  logic          ctl_wr,
    input  logic          ctl_buffered,
    input  logic          ctl_rx,
    input  logic          ctl_go,
    input  logic          irq_clr,
    output logic          irq,
    output logic [7:0]    status,
    output logic          eng_req,
    output logic          eng_rx,
    output logic [DW-1:0] eng_txbyte,
    output logic          eng_nack,
    input  logic          eng_done,
    input  logic          eng_ack,
    input  logic [DW-1:0] eng_rxbyte,
    input  logic          eng_stop
);
    logic [CW-1:0] ptr_w, bound_w, moved_w;
    logic          buf_we_w, buf_from_eng_w, cnt_load_ok_w;
    logic          moved_clr_w, moved_inc_w, moved_load_w;
    logic          lb_w, cnt_ok_w, last_pos_w;
    logic [DW-1:0] buf_wdata_w, buf_rdata_w;

    assign buf_wdata_w = buf_from_eng_w ? eng_rxbyte : dat_wdata;
    assign dat_rdata   = buf_rdata_w;
    assign eng_txbyte  = buf_rdata_w;

    bxf_count #(.DEPTH(DEPTH), .CW(CW)) count_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cnt_wr && cnt_load_ok_w),
        .wdata      (cnt_wdata),
        .moved_clr  (moved_clr_w),
        .moved_inc  (moved_inc_w),
        .moved_load (moved_load_w),
        .cnt_rdata  (cnt_rdata),
        .lb         (lb_w),
        .bound      (bound_w),
        .cnt_ok     (cnt_ok_w),
        .last_pos   (last_pos_w),
        .moved      (moved_w)
    );

    bxf_seq #(.DEPTH(DEPTH), .CW(CW)) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .dat_wr       (dat_wr),
        .dat_rd       (dat_rd),
        .cnt_wr       (cnt_wr),
        .ctl_wr       (ctl_wr),
        .ctl_buffered (ctl_buffered),
        .ctl_rx       (ctl_rx),
        .ctl_go       (ctl_go),
        .irq_clr      (irq_clr),
        .bound        (bound_w),
        .lb           (lb_w),
        .cnt_ok       (cnt_ok_w),
        .last_pos     (last_pos_w),
        .eng_done     (eng_done),
        .eng_ack      (eng_ack),
        .eng_stop     (eng_stop),
        .ptr          (ptr_w),
        .buf_we       (buf_we_w),
        .buf_from_eng (buf_from_eng_w),
        .cnt_load_ok  (cnt_load_ok_w),
        .moved_clr    (moved_clr_w),
        .moved_inc    (moved_inc_w),
        .moved_load   (moved_load_w),
        .eng_req      (eng_req),
        .eng_rx       (eng_rx),
        .eng_nack     (eng_nack),
        .irq          (irq),
        .status       (status)
    );

    bxf_buffer #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) buffer_i (
        .clk   (clk),
        .we    (buf_we_w),
        .addr  (ptr_w),
        .wdata (buf_wdata_w),
        .rdata (buf_rdata_w)
    );

    // R4: during a burst the buffer pointer and the moved counter advance together
    assert_ptr_tracks_moved_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> (ptr_w == moved_w));

endmodule

// File: tb/i2c_burst_ctrl_tb_top.sv
module i2c_burst_ctrl_tb_top;
    localparam int DEPTH = 68;
    localparam int DW    = 8;
    localparam int CW    = 7;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          cnt_wr, dat_wr, dat_rd, ctl_wr, ctl_buffered, ctl_rx, ctl_go, irq_clr;
    logic [CW:0]   cnt_wdata, cnt_rdata;
    logic [DW-1:0] dat_wdata, dat_rdata, eng_txbyte, eng_rxbyte;
    logic          irq, eng_req, eng_rx, eng_nack, eng_done, eng_ack, eng_stop;
    logic [7:0]    status;

    i2c_burst_ctrl #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd), .dat_rdata(dat_rdata),
        .ctl_wr(ctl_wr), .ctl_buffered(ctl_buffered), .ctl_rx(ctl_rx), .ctl_go(ctl_go),
        .irq_clr(irq_clr), .irq(irq), .status(status), .eng_req(eng_req), .eng_rx(eng_rx),
        .eng_txbyte(eng_txbyte), .eng_nack(eng_nack), .eng_done(eng_done), .eng_ack(eng_ack),
        .eng_rxbyte(eng_rxbyte), .eng_stop(eng_stop)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [DW-1:0] exp_buf [DEPTH];
    int  ptr_m = 0;
    int  bc_m  = 0;
    bit  lb_m  = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int bound_m();
        return (bc_m > DEPTH) ? DEPTH : bc_m;
    endfunction

    function automatic int exp_moved(bit rx, int n, int stop_at, int nack_at);
        for (int i = 0; i < n; i++) begin
            if (i == stop_at) return i;
            if (!rx && i == nack_at) return i + 1;
        end
        return n;
    endfunction

    function automatic int exp_status(bit rx, int n, bit lb, int stop_at, int nack_at);
        for (int i = 0; i < n; i++) begin
            if (i == stop_at) return 'hA0;
            if (!rx && i == nack_at) return 'h30;
        end
        if (rx) return lb ? 'h58 : 'h50;
        return 'h28;
    endfunction

    task automatic write_count(logic [7:0] v);
        cnt_wdata = v; cnt_wr = 1'b1;
        @(negedge clk);
        cnt_wr = 1'b0;
        bc_m = int'(v[6:0]); lb_m = v[7]; ptr_m = 0;
    endtask

    task automatic host_wr(logic [7:0] b);
        dat_wdata = b; dat_wr = 1'b1;
        @(negedge clk);
        dat_wr = 1'b0;
        if (ptr_m < bound_m()) begin
            exp_buf[ptr_m] = b;
            ptr_m++;
        end
    endtask

    task automatic host_rd(string tag);
        if (ptr_m < bound_m()) chk(tag, dat_rdata, exp_buf[ptr_m]);
        dat_rd = 1'b1;
        @(negedge clk);
        dat_rd = 1'b0;
        if (ptr_m < bound_m()) ptr_m++;
    endtask

    task automatic ctl(bit m, bit r, bit g);
        ctl_buffered = m; ctl_rx = r; ctl_go = g; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk("R11 irq cleared", irq, 0);
        chk("R11 status idle after clear", status, 'hF8);
    endtask

    // Starts a burst, plays the engine, then checks the end report.
    task automatic run_seq(bit rx, int n, int stop_at, int nack_at, int lat);
        int idx;
        int guard;
        int mv;
        logic [7:0] b;
        idx = 0; guard = 0;
        ctl(1'b1, rx, 1'b1);
        while (!irq && guard < 4000) begin
            guard++;
            if (eng_req) begin
                chk("R4 direction", eng_rx, rx);
                if (!rx) begin
                    chk("R4 tx byte order", eng_txbyte, exp_buf[idx]);
                    chk("R12 no nack in tx", eng_nack, 0);
                end else if (lb_m) begin
                    chk("R7 nack on final only", eng_nack, (idx == n - 1) ? 1 : 0);
                end else begin
                    chk("R6 nack clear", eng_nack, 0);
                end
                repeat ($urandom_range(0, lat)) @(negedge clk);
                if (idx == stop_at) begin
                    eng_stop = 1'b1;
                    @(negedge clk);
                    eng_stop = 1'b0;
                end else begin
                    eng_done = 1'b1;
                    eng_ack  = rx ? 1'b1 : (idx != nack_at);
                    if (rx) begin
                        b = 8'($urandom);
                        eng_rxbyte = b;
                        exp_buf[idx] = b;
                    end
                    @(negedge clk);
                    eng_done = 1'b0;
                    idx++;
                end
            end else begin
                @(negedge clk);
            end
        end
        mv = exp_moved(rx, n, stop_at, nack_at);
        chk("R9 irq at end", irq, 1);
        chk(stop_at >= 0 ? "R8 stop status" : (rx ? (lb_m ? "R7 status" : "R6 status")
            : (nack_at >= 0 ? "R5 nack status" : "R4 status")),
            status, exp_status(rx, n, lb_m, stop_at, nack_at));
        chk("R9 count reports moved", cnt_rdata, {lb_m, 7'(mv)});
        bc_m = mv; ptr_m = 0;
        if (rx) begin
            for (int k = 0; k < mv; k++) host_rd("R6 R9 received data from entry 0");
        end else if (mv > 0) begin
            host_rd("R9 pointer home after tx");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, stop_at, nack_at;
        bit rx, lb;
        void'($urandom(32'd7121));
        rst_n = 1'b0;
        {cnt_wr, dat_wr, dat_rd, ctl_wr, ctl_buffered, ctl_rx, ctl_go, irq_clr} = '0;
        {eng_done, eng_ack, eng_stop} = '0;
        cnt_wdata = '0; dat_wdata = '0; eng_rxbyte = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1
        chk("R1 irq after reset", irq, 0);
        chk("R1 status after reset", status, 'hF8);
        chk("R1 count after reset", cnt_rdata, 0);
        chk("R1 no request after reset", eng_req, 0);

        // R10: buffered bit clear
        write_count(8'h03);
        ctl(1'b0, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        chk("R10 no request", eng_req, 0);
        chk("R10 no irq", irq, 0);
        chk("R10 status unchanged", status, 'hF8);

        // R3: zero count and one past the buffer
        write_count(8'h00);
        ctl(1'b1, 1'b0, 1'b1);
        chk("R3 no request", eng_req, 0);
        @(negedge clk);
        chk("R3 irq on zero count", irq, 1);
        chk("R3 status FC", status, 'hFC);
        chk("R3 no request after reject", eng_req, 0);
        clear_irq();
        write_count(8'h45);
        ctl(1'b1, 1'b0, 1'b1);
        @(negedge clk);
        chk("R3 irq on 45h", irq, 1);
        chk("R3 status FC on 45h", status, 'hFC);
        chk("R3 count kept", cnt_rdata, 'h45);
        clear_irq();

        // R12: full 44h transmit with bit 7 set
        write_count(8'hC4);
        for (int k = 0; k < DEPTH; k++) host_wr(8'($urandom));
        run_seq(1'b0, DEPTH, -1, -1, 1);
        clear_irq();

        // R2: writes past the count are ignored
        write_count(8'h02);
        host_wr(8'h11); host_wr(8'h22); host_wr(8'h33);
        write_count(8'h03);
        host_rd("R2 entry 0"); host_rd("R2 entry 1"); host_rd("R2 entry 2 untouched");

        // R5 and R11: NACK on first byte, then a start while irq is pending
        write_count(8'h02);
        host_wr(8'hA5); host_wr(8'h5A);
        run_seq(1'b0, 2, -1, 0, 0);
        ctl(1'b1, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        chk("R11 start ignored while irq", eng_req, 0);
        chk("R11 irq still set", irq, 1);
        chk("R11 status kept", status, 'h30);
        clear_irq();

        // R7, R6, R8 directed
        write_count(8'h85);
        run_seq(1'b1, 5, -1, -1, 2);
        clear_irq();
        write_count(8'h04);
        run_seq(1'b1, 4, -1, -1, 0);
        clear_irq();
        write_count(8'h05);
        for (int k = 0; k < 5; k++) host_wr(8'($urandom));
        run_seq(1'b0, 5, 2, -1, 1);
        clear_irq();

        // Random bursts
        for (int it = 0; it < 24; it++) begin
            rx = 1'($urandom_range(0, 1));
            lb = 1'($urandom_range(0, 1));
            n  = $urandom_range(1, DEPTH);
            stop_at = -1; nack_at = -1;
            if ($urandom_range(0, 3) == 0) stop_at = $urandom_range(0, n - 1);
            else if (!rx && $urandom_range(0, 2) == 0) nack_at = $urandom_range(0, n - 1);
            write_count({lb, 7'(n)});
            if (!rx) for (int k = 0; k < n; k++) host_wr(8'($urandom));
            run_seq(rx, n, stop_at, nack_at, 3);
            clear_irq();
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule